// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to eleven interrupt event lines for a small 8-bit processor core. Each event is caught in its own pending flag. A flag stays set until the controller services that interrupt or a reset occurs. A pending flag turns into a request only when software has set the matching bit of the enable mask. A single global enable bit then decides whether the core may be interrupted at all.

At every instruction boundary that the core signals, the controller takes the request with the smallest source number, provided the global enable is set. In that one clock edge it does three things: it clears the global enable, it clears the pending flag of the chosen source, and it presents a one-cycle take pulse together with the ROM vector address. The vector address is twice the source number. The core then performs the automatic call to that address.

The core reports its enable-interrupts, disable-interrupts and return-from-interrupt instructions as single-cycle pulses. These pulses only move the global enable. Software can read two status bits: a sense bit that shows whether any enabled interrupt is pending, even while interrupts are globally off, and the global enable itself.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable mask, all pending flags and the global enable are 0. The outputs read take=0, take_vec=0, irq_sense=0 and gie=0.
- R2: A pulse on src_fire bit i (source i+1) sets that source's pending flag at the next edge. The flag stays set while the source is masked and while interrupts are globally off, until that source is serviced.
- R3: A pulse on en_wr loads en_wdata into the enable mask. A bit value of 1 enables its source. A pending source whose enable bit is 0 never causes a take and does not raise irq_sense.
- R4: Among the enabled pending sources, the one with the lowest bit index (source 1 = bit 0) is always taken first. take_vec equals 2*(i+1) for bit i, so 0x02 is used for bit 0 and 0x16 for bit 10.
- R5: Sources 6 to 9 (src_fire bits 5 to 8) are reserved. Pulses on these bits have no effect on pending state, irq_sense or take.
- R6: take is high for exactly one cycle. It goes high only in the cycle after an edge at which boundary=1, gie=1 and at least one enabled source was pending. take_vec is 0 whenever take is 0.
- R7: The edge that raises take also clears gie and clears the pending flag of the taken source only.
- R8: An ei or reti pulse sets gie, and a di pulse clears it. When several of these coincide, a take wins over di, and di wins over ei and reti. These pulses change no other state.
- R9: irq_sense equals the OR of (pending AND enabled) over all sources, whatever the value of gie.
- R10: If a source fires in the same cycle that its pending flag is being cleared by a take, the flag stays set.
- R11: Interrupts may nest. After a take, setting gie again with ei allows another take at the next boundary strobe, and the block imposes no depth limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_fire | input | 11 | Event pulses; bit i is source i+1 |
| en_wr | input | 1 | Enable-mask write strobe |
| en_wdata | input | 11 | New enable mask |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| ei | input | 1 | Enable-interrupts instruction pulse |
| di | input | 1 | Disable-interrupts instruction pulse |
| reti | input | 1 | Return-from-interrupt pulse |
| take | output | 1 | One-cycle interrupt call request |
| take_vec | output | 8 | Vector address to call while take is high |
| irq_sense | output | 1 | Any enabled interrupt pending |
| gie | output | 1 | Global interrupt enable state |

## Verification
Several directed patterns test the priority pick. One has several pending sources at once and shows whether the lowest index wins and whether the others are kept. One fires while the source is masked and separates latching from passing the event straight through. One fires the reserved bits only, which exposes any leak through those slots. One fires a source in the same cycle it is taken, which separates set-wins from clear-wins. Colliding ei, di and reti pulses, with and without a take, pin down the precedence on gie. Long random runs with sparse events and random boundary strobes then compare every output each cycle against a reference model in the bench.

// File: rtl/irq_pkg.sv
// Shared constants and helpers for the vectored interrupt controller.
// Assumes sources are numbered from 1, with bit 0 being source 1.
package irq_pkg;
    localparam int unsigned NSRC_DEF  = 11;
    localparam int unsigned VEC_W_DEF = 8;
    // Bits 5..8 (sources 6..9) are reserved slots that never raise a request.
    localparam logic [NSRC_DEF-1:0] RSV_DEF = 11'b001_1110_0000;

    // Vector address of a zero-based source index: two-byte slots from 0x02.
    function automatic int unsigned vec_of(input int unsigned idx);
        return (idx + 1) * 2;
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
// Pending flag bank: one flag per source. A fire sets the flag and a clear
// from acknowledge resets it, but a fire in the same cycle wins. Reserved
// slots are masked off at the input. Assumes single-cycle fire pulses.
module irq_pend_bank #(
    parameter int unsigned      NSRC = 11,
    parameter logic [NSRC-1:0]  RSV  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] fire,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend_q
);
    logic [NSRC-1:0] fire_ok;

    // Drop events on reserved slots.
    assign fire_ok = fire & ~RSV;

    // Update pending flags; a set overrides a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | fire_ok;
    end

    // A non-reserved fire is always pending at the following edge.
    assert_fire_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire_ok) |=> ((pend_q & $past(fire_ok)) == $past(fire_ok)));

    // A flag cannot drop unless acknowledge cleared it.
    assert_pend_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~pend_q) & ~$past(clr)) == '0));
endmodule

// File: rtl/irq_prio_sel.sv
// Fixed-priority selector: the lowest set index of req wins. Produces a
// one-hot grant, an any flag and the vector address of the winner.
// Purely combinational; assumes VEC_W is wide enough for 2*NSRC.
module irq_prio_sel #(
    parameter int unsigned NSRC  = 11,
    parameter int unsigned VEC_W = 8
) (
    input  logic [NSRC-1:0]  req,
    output logic [NSRC-1:0]  grant,
    output logic             any,
    output logic [VEC_W-1:0] vec
);
    logic [NSRC:0] seen;

    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_chain
            // A bit wins only if no lower index is requesting.
            assign grant[g]  = req[g] & ~seen[g];
            assign seen[g+1] = seen[g] | req[g];
        end
    endgenerate

    assign any = seen[NSRC];

    // Encode the winning slot into its two-byte vector address.
    always_comb begin
        vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) vec = VEC_W'(irq_pkg::vec_of(i));
        end
    end
endmodule

// File: rtl/irq_gie_ctl.sv
// Global interrupt enable flag. A take clears it first; then di clears it;
// then ei or reti sets it. Assumes single-cycle instruction pulses.
module irq_gie_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic take_now,
    input  logic ei,
    input  logic di,
    input  logic reti,
    output logic gie_q
);
    // Resolve the enable flag by fixed precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)          gie_q <= 1'b0;
        else if (take_now)   gie_q <= 1'b0;
        else if (di)         gie_q <= 1'b0;
        else if (ei || reti) gie_q <= 1'b1;
    end

    // Enable instructions without a competing clear turn interrupts on.
    assert_gie_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ei || reti) && !di && !take_now) |=> gie_q);

    // Without any control pulse the flag holds.
    assert_gie_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ei && !di && !reti && !take_now) |=> $stable(gie_q));
endmodule

// File: rtl/irq_vector_ctrl.sv
// Prioritized vectored interrupt controller. It latches source events,
// masks them per source and globally, and at an instruction boundary
// acknowledges the winning request in one edge: it clears gie and the
// winner's pending flag and emits a one-cycle take with the vector address.
// Assumes the core holds boundary for one cycle per completed instruction.
module irq_vector_ctrl #(
    parameter int unsigned          NSRC  = irq_pkg::NSRC_DEF,
    parameter int unsigned          VEC_W = irq_pkg::VEC_W_DEF,
    parameter logic [NSRC-1:0]      RSV   = irq_pkg::RSV_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_fire,
    input  logic             en_wr,
    input  logic [NSRC-1:0]  en_wdata,
    input  logic             boundary,
    input  logic             ei,
    input  logic             di,
    input  logic             reti,
    output logic             take,
    output logic [VEC_W-1:0] take_vec,
    output logic             irq_sense,
    output logic             gie
);
    localparam int unsigned MAX_VEC = 2 * NSRC;

    logic [NSRC-1:0]  pend_q;
    logic [NSRC-1:0]  en_q;
    logic [NSRC-1:0]  req;
    logic [NSRC-1:0]  grant;
    logic [NSRC-1:0]  clr;
    logic             any_req;
    logic             take_now;
    logic             gie_q;
    logic [VEC_W-1:0] win_vec;
    logic             take_q;
    logic [VEC_W-1:0] vec_q;

    // Enable mask register, loaded whole by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    assign req = pend_q & en_q;

    irq_pend_bank #(.NSRC(NSRC), .RSV(RSV)) u_pend (
        .clk(clk), .rst_n(rst_n), .fire(src_fire), .clr(clr), .pend_q(pend_q)
    );

    irq_prio_sel #(.NSRC(NSRC), .VEC_W(VEC_W)) u_sel (
        .req(req), .grant(grant), .any(any_req), .vec(win_vec)
    );

    // Acknowledge only at a boundary with interrupts globally on.
    assign take_now = boundary & gie_q & any_req;
    assign clr      = take_now ? grant : '0;

    irq_gie_ctl u_gie (
        .clk(clk), .rst_n(rst_n), .take_now(take_now),
        .ei(ei), .di(di), .reti(reti), .gie_q(gie_q)
    );

    // Register the call request and its vector for the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= take_now;
            vec_q  <= take_now ? win_vec : '0;
        end
    end

    assign take      = take_q;
    assign take_vec  = vec_q;
    assign irq_sense = |req;
    assign gie       = gie_q;

    // At most one source is granted at a time.
    assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // A take follows a boundary with interrupts enabled.
    assert_take_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($past(boundary) && $past(gie_q)));

    // The taking edge has also cleared the global enable.
    assert_take_clears_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !gie_q);

    // The vector is an even, in-range slot, never the reset entry.
    assert_vec_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (take_vec[0] == 1'b0 && take_vec >= VEC_W'(2)
                  && take_vec <= VEC_W'(MAX_VEC)));

    // A take never repeats on consecutive cycles (gie was cleared).
    assert_take_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
// Bench: directed corner cases plus seeded random traffic, each cycle
// compared against a reference model built from the requirements.
module sim_irq_vector_ctrl;
    localparam int N = 11;
    localparam logic [N-1:0] RSV = 11'b001_1110_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_fire = '0;
    logic en_wr = 1'b0;
    logic [N-1:0] en_wdata = '0;
    logic boundary = 1'b0, ei = 1'b0, di = 1'b0, reti = 1'b0;
    logic take, irq_sense, gie;
    logic [7:0] take_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [N-1:0] m_pend = '0, m_en = '0;
    logic m_gie = 1'b0;

    always #4 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_fire(src_fire), .en_wr(en_wr),
        .en_wdata(en_wdata), .boundary(boundary), .ei(ei), .di(di),
        .reti(reti), .take(take), .take_vec(take_vec),
        .irq_sense(irq_sense), .gie(gie)
    );

    function automatic int pick(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs, advance the model, compare after the edge.
    task automatic step(input string tag, input logic [N-1:0] f, input logic w,
                        input logic [N-1:0] wd, input logic b, input logic e,
                        input logic d, input logic r);
        logic [N-1:0] rq, cl;
        logic t;
        int k;
        int ev;
        src_fire = f; en_wr = w; en_wdata = wd;
        boundary = b; ei = e; di = d; reti = r;
        rq = m_pend & m_en;
        k  = pick(rq);
        t  = b && m_gie && (k >= 0);
        cl = t ? (N'(1) << k) : '0;
        ev = t ? 2 * (k + 1) : 0;
        m_pend = (m_pend & ~cl) | (f & ~RSV);
        if (w) m_en = wd;
        if (t)           m_gie = 1'b0;
        else if (d)      m_gie = 1'b0;
        else if (e || r) m_gie = 1'b1;
        @(posedge clk); #1;
        chk(tag, "take", int'(take), int'(t));
        chk(tag, "take_vec", int'(take_vec), ev);
        chk(tag, "gie", int'(gie), int'(m_gie));
        chk(tag, "irq_sense", int'(irq_sense), int'(|(m_pend & m_en)));
    endtask

    task automatic idle(input string tag);
        step(tag, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] rf;
        void'($urandom(32'h1a2b3c));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "take", int'(take), 0);
        chk("R1", "take_vec", int'(take_vec), 0);
        chk("R1", "gie", int'(gie), 0);
        chk("R1", "irq_sense", int'(irq_sense), 0);
        rst_n = 1'b1;
        idle("R1");

        // R2/R3: fire while masked, then enable and take.
        step("R2", 11'h004, 0, '0, 0, 0, 0, 0);
        step("R3", '0, 0, '0, 1, 1, 0, 0);
        step("R3", '0, 0, '0, 1, 0, 0, 0);
        step("R9", '0, 1, 11'h7FF, 0, 0, 0, 0);
        step("R6", '0, 0, '0, 1, 0, 0, 0);
        step("R7", '0, 0, '0, 1, 0, 0, 0);

        // R4: three pending, taken lowest first.
        step("R4", 11'h409, 0, '0, 0, 0, 0, 1);
        step("R4", '0, 0, '0, 1, 0, 0, 0);
        step("R9", '0, 0, '0, 0, 1, 0, 0);
        step("R4", '0, 0, '0, 1, 0, 0, 0);
        step("R4", '0, 0, '0, 0, 0, 0, 1);
        step("R4", '0, 0, '0, 1, 0, 0, 0);

        // R5: reserved slots only.
        step("R5", 11'h1E0, 0, '0, 0, 1, 0, 0);
        step("R5", '0, 0, '0, 1, 0, 0, 0);

        // R10: fire the source being taken.
        step("R10", 11'h002, 0, '0, 0, 0, 0, 0);
        step("R10", 11'h002, 0, '0, 1, 0, 0, 0);
        idle("R10");

        // R8: precedence on gie.
        step("R8", '0, 0, '0, 0, 1, 1, 0);
        step("R8", '0, 0, '0, 0, 0, 0, 1);
        step("R8", '0, 0, '0, 1, 1, 0, 1);
        step("R8", '0, 0, '0, 0, 1, 0, 0);
        step("R8", '0, 0, '0, 0, 0, 1, 0);

        // R11: nested take after ei inside handler.
        step("R11", 11'h400, 0, '0, 0, 1, 0, 0);
        step("R11", '0, 0, '0, 1, 0, 0, 0);
        step("R11", 11'h001, 0, '0, 0, 1, 0, 0);
        step("R11", '0, 0, '0, 1, 0, 0, 0);
        step("R11", '0, 0, '0, 0, 0, 0, 1);
        step("R11", '0, 0, '0, 1, 0, 0, 0);

        // R6: no take without a boundary or with gie low.
        step("R6", 11'h010, 0, '0, 0, 0, 1, 0);
        step("R6", '0, 0, '0, 1, 0, 0, 0);
        step("R6", '0, 0, '0, 0, 1, 0, 0);
        step("R6", '0, 0, '0, 0, 0, 0, 0);
        step("R6", '0, 0, '0, 1, 0, 0, 0);

        // Random traffic across all requirements (R2 R3 R4 R8 R9 R10).
        for (int c = 0; c < 4000; c++) begin
            rf = N'($urandom & $urandom & $urandom);
            step("R4", rf, ($urandom % 16) == 0, N'($urandom),
                 ($urandom % 2) == 0, ($urandom % 6) == 0,
                 ($urandom % 14) == 0, ($urandom % 8) == 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule